// File: doc/BRIEF.md
# Load/Store Multiple Register Sequencer

This block carries out the four block-transfer instructions of a small 32-bit core that has sixteen general registers and 16-bit instruction words. When it receives a start pulse, it decodes the instruction word and captures the base address from the register file through its read port. It then moves a group of registers to or from consecutive word addresses, one word per memory transfer. There are two kinds of group. The quadrant forms move a fixed set of four registers and take their base from a register chosen by the instruction. The range forms move every register from a chosen first register up to register 15 and always take their base from register 0.

Memory requests use a valid/ready channel. Once the block raises `mem_req_valid`, it holds the request (address, write flag and write data) unchanged until `mem_req_ready` is seen high at a clock edge. The memory may hold off ready for any number of cycles. The block has at most one request outstanding. A store word is complete at its request handshake. A load word is complete when `mem_rsp_valid` arrives on some later cycle, and the block always accepts that response in the cycle it arrives. The register file, the memory and the start source all sit outside the block.

Encodings that name an overlapping or out-of-range register are rejected. For these the block raises `illegal` for one cycle and makes no transfer.

Top module: `blkxfer_seq`

## Requirements
- R1: A start is accepted only when the block is idle and `instr[15:6]` equals `0000000001`. For any other word the start has no effect: no busy, no illegal flag, no memory request and no register write.
- R2: `instr[5:4]` selects the operation: 00 loads the quadrant, 01 stores the quadrant, 10 loads the range, 11 stores the range. `instr[3:0]` is the register field.
- R3: The quadrant forms transfer registers 4, 5, 6 and 7. The first address is the value of the register named by the field, read at the start.
- R4: The range forms transfer registers field through 15. The first address is the value of register 0, read at the start.
- R5: Registers are transferred lowest-numbered first. The byte address starts at the base and rises by 4 for each word.
- R6: The base register is never written. A load writes only the registers of its group, and a store writes no register.
- R7: A range form with field 0 or 15, or a quadrant load whose base register is 4 to 7, is illegal. The block raises `illegal` for exactly one cycle, the cycle after the start, and makes no memory request, no register write and no busy cycle.
- R8: A quadrant store whose base register lies inside the quadrant is carried out. It stores four words, and each word is the value its register held at the start.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and its address, write flag and write data stay unchanged.
- R10: `busy` is high from the cycle after an accepted legal start until the last word completes. `done` is then high for one cycle with `busy` low. After reset `busy`, `done`, `illegal` and `mem_req_valid` are low.
- R11: A start that arrives while `busy` is high is ignored.
- R12: For a load, the register is written (`rf_we` high) only in a cycle in which `mem_rsp_valid` is high, and the write carries the response data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the instruction on `instr` |
| instr | input | 16 | Instruction word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the last word completes |
| illegal | output | 1 | One-cycle pulse for a rejected encoding |
| rf_raddr | output | 4 | Register file read address |
| rf_rdata | input | 32 | Register file read data, combinational from `rf_raddr` |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write address |
| rf_wdata | output | 32 | Register file write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for a store, 0 for a load |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Store data |
| mem_rsp_valid | input | 1 | Load data valid |
| mem_rsp_rdata | input | 32 | Load data |

## Verification
The assertions check the following on every cycle: the request is held steady under back-pressure, the block makes no memory request or register write while idle, register writes occur only alongside a response, `done` and `illegal` never overlap busy time, and `done` lasts a single cycle. Some behaviours can only be shown by the bench's scenarios: the register set each form selects, the base each form reads, the ascending address order and the data that ends up in registers and memory. The bench sweeps all four sub-opcodes across all sixteen register-field values and compares the results with values it computes arithmetically. It also tests starts on words outside the group and a start issued while busy.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    OP_QLD = 2'b00,
    OP_QST = 2'b01,
    OP_RLD = 2'b10,
    OP_RST = 2'b11
  } xfer_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_RSP  = 2'b10
  } seq_state_e;

  localparam logic [9:0] GROUP_PREFIX = 10'b0000000001;
endpackage

// File: rtl/blkxfer_decode.sv
module blkxfer_decode
  import blkxfer_pkg::*;
#(
  parameter int REG_AW  = 4,
  parameter int QUAD_LO = 4
) (
  input  logic [15:0]       instr,
  output logic              hit,
  output xfer_op_e          op,
  output logic [REG_AW-1:0] base_reg,
  output logic [REG_AW-1:0] first_reg,
  output logic [REG_AW-1:0] last_reg,
  output logic              bad
);
  localparam int QUAD_HI = QUAD_LO + 3;
  localparam int TOP_REG = (1 << REG_AW) - 1;

  logic [REG_AW-1:0] field;
  logic              field_in_quad;

  assign field         = instr[REG_AW-1:0];
  assign hit           = (instr[15:6] == GROUP_PREFIX);
  assign op            = xfer_op_e'(instr[5:4]);
  assign field_in_quad = (int'(field) >= QUAD_LO) && (int'(field) <= QUAD_HI);

  always_comb begin
    if (!op[1]) begin
      base_reg  = field;
      first_reg = REG_AW'(QUAD_LO);
      last_reg  = REG_AW'(QUAD_HI);
      bad       = (op == OP_QLD) && field_in_quad;
    end else begin
      base_reg  = '0;
      first_reg = field;
      last_reg  = REG_AW'(TOP_REG);
      bad       = (field == '0) || (field == REG_AW'(TOP_REG));
    end
  end
endmodule

// File: rtl/blkxfer_cursor.sv
module blkxfer_cursor #(
  parameter int REG_AW     = 4,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [REG_AW-1:0] first_reg,
  input  logic [REG_AW-1:0] last_reg,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [REG_AW-1:0] cur_reg,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

  logic [REG_AW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_reg  <= '0;
      cur_addr <= '0;
      last_q   <= '0;
    end else if (load) begin
      cur_reg  <= first_reg;
      cur_addr <= base_addr;
      last_q   <= last_reg;
    end else if (step) begin
      cur_reg  <= cur_reg + 1'b1;
      cur_addr <= cur_addr + STRIDE;
    end
  end

  assign at_last = (cur_reg == last_q);
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int REG_AW  = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int QUAD_LO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       instr,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [REG_AW-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  localparam int WORD_BYTES = DATA_W / 8;

  seq_state_e        state_q, state_d;
  logic              load_q;
  logic              illegal_q, done_q;
  logic              dec_hit, dec_bad;
  xfer_op_e          dec_op;
  logic [REG_AW-1:0] dec_base, dec_first, dec_last;
  logic [REG_AW-1:0] cur_reg;
  logic [ADDR_W-1:0] cur_addr;
  logic              at_last;
  logic              accept, launch, req_hs, rsp_take, advance, finish;

  blkxfer_decode #(.REG_AW(REG_AW), .QUAD_LO(QUAD_LO)) u_dec (
    .instr(instr), .hit(dec_hit), .op(dec_op), .base_reg(dec_base),
    .first_reg(dec_first), .last_reg(dec_last), .bad(dec_bad)
  );

  blkxfer_cursor #(.REG_AW(REG_AW), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_cur (
    .clk(clk), .rst_n(rst_n), .load(launch), .step(advance && !at_last),
    .first_reg(dec_first), .last_reg(dec_last), .base_addr(ADDR_W'(rf_rdata)),
    .cur_reg(cur_reg), .cur_addr(cur_addr), .at_last(at_last)
  );

  assign accept   = start && (state_q == ST_IDLE) && dec_hit;
  assign launch   = accept && !dec_bad;
  assign req_hs   = (state_q == ST_REQ) && mem_req_ready;
  assign rsp_take = (state_q == ST_RSP) && mem_rsp_valid;
  assign advance  = (req_hs && !load_q) || rsp_take;
  assign finish   = advance && at_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch) state_d = ST_REQ;
      ST_REQ:  if (req_hs) state_d = load_q ? ST_RSP : (at_last ? ST_IDLE : ST_REQ);
      ST_RSP:  if (rsp_take) state_d = at_last ? ST_IDLE : ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      load_q    <= 1'b0;
      illegal_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_q <= accept && dec_bad;
      done_q    <= finish;
      if (launch) load_q <= !dec_op[0];
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign illegal       = illegal_q;
  assign rf_raddr      = (state_q == ST_IDLE) ? dec_base : cur_reg;
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_write = !load_q;
  assign mem_req_addr  = cur_addr;
  assign mem_req_wdata = rf_rdata;
  assign rf_we         = rsp_take;
  assign rf_waddr      = cur_reg;
  assign rf_wdata      = mem_rsp_rdata;
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
  parameter int REG_AW = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              rf_we,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !rf_we));

  // R12
  write_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_rsp_valid);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !done));
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .illegal(illegal),
  .rf_we(rf_we), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/blkxfer_seq_test.sv
`timescale 1ns/1ps
module blkxfer_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        busy, done, illegal, rf_we, mem_req_valid, mem_req_write;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, mem_req_addr, mem_req_wdata;
  logic        mem_req_ready;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  logic [31:0] rf [16];
  logic [31:0] mem [256];
  logic [31:0] rf_exp [16];
  logic [31:0] mem_exp [256];
  logic [31:0] addr_log [32];
  int hs_cnt, done_cnt, ill_cnt, busy_cnt;
  int tests = 0, fails = 0;
  logic [7:0] rdy_cnt = '0;

  blkxfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .busy(busy), .done(done),
    .illegal(illegal), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  assign rf_rdata      = rf[rf_raddr];
  assign mem_req_ready = (rdy_cnt[1:0] != 2'b01) && (rdy_cnt[4:2] != 3'b110);

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 8'd1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) mem[mem_req_addr[9:2]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[9:2]];
      end
    end
    if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) begin
        if (hs_cnt < 32) addr_log[hs_cnt] = mem_req_addr;
        hs_cnt = hs_cnt + 1;
      end
      if (done) begin
        done_cnt = done_cnt + 1;
        if (busy) busy_cnt = busy_cnt + 1000;
      end
      if (illegal) ill_cnt = ill_cnt + 1;
      if (busy) busy_cnt = busy_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic init_state(input int c);
    for (int i = 0; i < 16; i++) rf[i] = {8'h5A, 8'(c), 12'h0, 4'(i)};
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
    hs_cnt = 0; done_cnt = 0; ill_cnt = 0; busy_cnt = 0;
  endtask

  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((busy || (done_cnt == 0 && ill_cnt == 0)) && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input int sub, input int fld);
    bit quad, ld, bad;
    int first, last, n, bw, c;
    logic [31:0] basev;
    string rq;
    c = sub * 16 + fld;
    init_state(c);
    quad = (sub < 2); ld = (sub % 2 == 0);
    if (quad) begin
      rf[fld] = 32'h100; first = 4; last = 7;
      bad = ld && fld >= 4 && fld <= 7; rq = "R3";
    end else begin
      rf[0] = 32'h200; first = fld; last = 15;
      bad = (fld == 0) || (fld == 15); rq = "R4";
    end
    basev = quad ? 32'h100 : 32'h200;
    bw = int'(basev >> 2);
    n = bad ? 0 : last - first + 1;
    for (int i = 0; i < 16; i++) rf_exp[i] = rf[i];
    for (int i = 0; i < 256; i++) mem_exp[i] = mem[i];
    if (!bad) for (int k = 0; k < n; k++) begin
      if (ld) rf_exp[first + k] = mem[bw + k];
      else mem_exp[bw + k] = rf[first + k];
    end
    issue({10'b0000000001, 2'(sub), 4'(fld)});
    wait_idle();
    // R7 illegal one-cycle pulse
    check(ill_cnt == (bad ? 1 : 0), "R7", $sformatf("illegal pulses sub%0d f%0d", sub, fld), ill_cnt, bad ? 1 : 0);
    // R2 transfer count by sub-opcode
    check(hs_cnt == n, "R2", $sformatf("handshakes sub%0d f%0d", sub, fld), hs_cnt, n);
    // R10 done once, never with busy
    check(done_cnt == (bad ? 0 : 1) && busy_cnt < 1000 && (!bad || busy_cnt == 0), "R10",
          $sformatf("done/busy sub%0d f%0d", sub, fld), done_cnt * 100000 + busy_cnt, bad ? 0 : 1);
    // R5 ascending addresses
    for (int k = 0; k < n && k < 32; k++)
      check(addr_log[k] == basev + 32'(4 * k), "R5", $sformatf("addr %0d sub%0d f%0d", k, sub, fld),
            addr_log[k], basev + 32'(4 * k));
    // R6 / R12 registers (R3 / R4 group selection)
    for (int i = 0; i < 16; i++)
      check(rf[i] === rf_exp[i], ld ? "R12" : "R6", $sformatf("%s reg%0d sub%0d f%0d", rq, i, sub, fld),
            rf[i], rf_exp[i]);
    // R8 store data, R3/R4 group memory image
    for (int i = 60; i < 150; i++)
      if (mem[i] !== mem_exp[i])
        check(1'b0, (quad && !ld && fld >= 4 && fld <= 7) ? "R8" : rq,
              $sformatf("mem word %0d sub%0d f%0d", i, sub, fld), mem[i], mem_exp[i]);
    check(1'b1, rq, "group", 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    init_state(0);
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !illegal && !mem_req_valid, "R10", "reset outputs",
          {busy, done, illegal, mem_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int sub = 0; sub < 4; sub++)
      for (int fld = 0; fld < 16; fld++)
        run_case(sub, fld);

    // R1 words outside the group are ignored
    for (int pfx = 0; pfx < 4; pfx++) begin
      init_state(200 + pfx);
      issue({10'(pfx == 1 ? 3 : pfx), 6'b110101});
      repeat (8) @(negedge clk);
      check(hs_cnt == 0 && ill_cnt == 0 && busy_cnt == 0 && done_cnt == 0, "R1",
            $sformatf("foreign word %0d", pfx), hs_cnt + ill_cnt + busy_cnt + done_cnt, 0);
      for (int i = 0; i < 16; i++)
        check(rf[i] == {8'h5A, 8'(200 + pfx), 12'h0, 4'(i)}, "R1", $sformatf("reg%0d untouched", i),
              rf[i], {8'h5A, 8'(200 + pfx), 12'h0, 4'(i)});
    end

    // R11 second start while busy ignored
    init_state(250);
    rf[2] = 32'h100; rf[0] = 32'h200;
    issue(16'h0052);
    @(negedge clk);
    instr = 16'h0062; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    check(hs_cnt == 4 && done_cnt == 1 && ill_cnt == 0, "R11", "handshakes with start while busy",
          hs_cnt, 4);
    for (int k = 0; k < 4; k++)
      check(mem[64 + k] == rf[4 + k], "R11", $sformatf("quad store word %0d", k), mem[64 + k], rf[4 + k]);
    check(mem[128] == (32'hC0DE_0000 | 32'd128), "R11", "range untouched", mem[128], 32'hC0DE_0080);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule